// File: doc/BRIEF.md
# Sixteen-bit ALU with excess word

This block is the arithmetic core of a small 16-bit processor. Each cycle in which `in_valid` is high it accepts a 5-bit operation code, a destination operand `b_in` and a source operand `a_in`. One clock edge later it presents a 16-bit result, a write strobe for the destination, and the cycle cost that the sequencer charges for the operation.

The block keeps one internal 16-bit state register, the excess word (XS). Most arithmetic operations load it with a side value: a carry flag, a borrow mask, the high half of a product, a fixed-point fraction of a quotient, or the bits a shift pushed out. The two carry-chaining operations also read it, so a multi-word add or subtract can be built from back-to-back operations. The move-with-increment operation also raises a one-cycle request to step the two index registers that the surrounding core owns. Operand fetch, memory access, conditional tests and sequencing are outside this block.

Top module: `exw_alu`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `out_valid`, `wr_en` and `idx_inc` are 0 and `xs_out` is 0x0000.
- R2: An accepted operation shows its outputs on the first rising edge after it is presented, with `out_valid` high for exactly that cycle. Codes outside the list in these requirements (for example 0x00, 0x10 and 0x1f) give `wr_en`=0, `result`=0 and cost 0, and leave XS unchanged.
- R3: Move (0x01) returns `a_in`. And (0x09), or (0x0a) and xor (0x0b) return the bitwise function of `b_in` and `a_in`. These four, remainder and move-with-increment leave XS unchanged.
- R4: Add (0x02) returns the low 16 bits of b+a and sets XS to 0x0001 if the sum exceeds 0xFFFF, else to 0x0000.
- R5: Subtract (0x03) returns the low 16 bits of b−a and sets XS to 0xFFFF if b<a, else to 0x0000.
- R6: Unsigned multiply (0x04) and signed multiply (0x05) return the low half of the 32-bit product and put its high half in XS. The signed variant treats both operands as two's complement.
- R7: Unsigned divide (0x06) returns b/a and sets XS to ((b·65536)/a) mod 65536. Signed divide (0x07) does the same in two's complement, with quotients truncated toward zero. With a=0 both return 0 and clear XS.
- R8: Remainder (0x08) returns b mod a (unsigned), or 0 when a=0.
- R9: Left shift (0x0e) returns (b<<a) mod 65536 with XS = bits 31..16 of b<<a. Logical right shift (0x0c) returns b>>a with XS = ((b·65536)>>a) mod 65536. Shift counts of 16 or more are honoured.
- R10: Arithmetic right shift (0x0d) shifts in copies of bit 15 of b. XS takes the bits shifted out, as in R9, with the vacated positions filled from the sign.
- R11: Move-with-increment (0x0f) returns `a_in` and raises `idx_inc` for its one output cycle. No other operation raises `idx_inc`.
- R12: Add-with-carry (0x1a) returns b+a+XS mod 65536 and sets XS to 1 on carry out, else 0. Subtract-with-borrow (0x1b) returns b−a−XS mod 65536 and sets XS to 1 if the result is negative, else 0. Both use the XS value left by the operation just before.
- R13: `cost` is 1 for move, and, or, xor; 2 for add, subtract, both multiplies, the three shifts and move-with-increment; 3 for both divides, remainder, add-with-carry and subtract-with-borrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 5 | Operation code |
| b_in | input | 16 | Destination operand value |
| a_in | input | 16 | Source operand value |
| out_valid | output | 1 | Result of the previous cycle's operation is present |
| result | output | 16 | Value to write to the destination |
| wr_en | output | 1 | Destination write strobe |
| xs_out | output | 16 | Current excess word |
| idx_inc | output | 1 | Request to step both index registers by one |
| cost | output | 2 | Cycle cost of the operation shown |

## Verification
The hazard is an XS update and an XS read in the same cycle. An operation that loads XS finishes on the same edge where a following carry-chaining operation is presented, and that operation must combine its operands with the value just written, not the older one. The bench sends unbroken streams of subtract, add-with-carry and subtract-with-borrow, mixed with divides and shifts that leave odd XS values. A bench-side model carries XS from operation to operation. Every result and XS value in the stream is checked against it, so any off-by-one-cycle use of the excess word shows up.

// File: rtl/exw_pkg.sv
package exw_pkg;

   typedef enum logic [4:0] {
      OP_MOVE   = 5'h01,
      OP_ADD    = 5'h02,
      OP_SUB    = 5'h03,
      OP_MULU   = 5'h04,
      OP_MULS   = 5'h05,
      OP_DIVU   = 5'h06,
      OP_DIVS   = 5'h07,
      OP_REM    = 5'h08,
      OP_AND    = 5'h09,
      OP_OR     = 5'h0a,
      OP_XOR    = 5'h0b,
      OP_SRL    = 5'h0c,
      OP_SRA    = 5'h0d,
      OP_SLL    = 5'h0e,
      OP_MOVINC = 5'h0f,
      OP_ADDC   = 5'h1a,
      OP_SUBB   = 5'h1b
   } exw_op_e;

   localparam int COST_W = 2;

   function automatic logic [COST_W-1:0] op_cost(input logic [4:0] code);
      case (code)
         OP_MOVE, OP_AND, OP_OR, OP_XOR:                   return 2'd1;
         OP_ADD, OP_SUB, OP_MULU, OP_MULS,
         OP_SRL, OP_SRA, OP_SLL, OP_MOVINC:                return 2'd2;
         OP_DIVU, OP_DIVS, OP_REM, OP_ADDC, OP_SUBB:       return 2'd3;
         default:                                          return 2'd0;
      endcase
   endfunction

   function automatic logic op_legal(input logic [4:0] code);
      return op_cost(code) != 2'd0;
   endfunction

endpackage

// File: rtl/exw_addsub.sv
module exw_addsub
   import exw_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [4:0]   op,
   input  logic [W-1:0] b,
   input  logic [W-1:0] a,
   input  logic [W-1:0] xs,
   output logic [W-1:0] res,
   output logic [W-1:0] xs_nx
);
   localparam int XW = W + 2;

   logic [XW-1:0] add_w, sub_w, addc_w, subb_w;

   always_comb begin
      add_w  = {2'b00, b} + {2'b00, a};
      sub_w  = {2'b00, b} - {2'b00, a};
      addc_w = {2'b00, b} + {2'b00, a} + {2'b00, xs};
      subb_w = {2'b00, b} - {2'b00, a} - {2'b00, xs};
   end

   always_comb begin
      res   = '0;
      xs_nx = xs;
      case (op)
         OP_ADD: begin
            res   = add_w[W-1:0];
            xs_nx = {{(W-1){1'b0}}, add_w[W]};
         end
         OP_SUB: begin
            res   = sub_w[W-1:0];
            xs_nx = {W{sub_w[XW-1]}};
         end
         OP_ADDC: begin
            res   = addc_w[W-1:0];
            xs_nx = {{(W-1){1'b0}}, |addc_w[XW-1:W]};
         end
         OP_SUBB: begin
            res   = subb_w[W-1:0];
            xs_nx = {{(W-1){1'b0}}, subb_w[XW-1]};
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/exw_muldiv.sv
module exw_muldiv
   import exw_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [4:0]   op,
   input  logic [W-1:0] b,
   input  logic [W-1:0] a,
   input  logic [W-1:0] xs,
   output logic [W-1:0] res,
   output logic [W-1:0] xs_nx
);
   localparam int PW = 2 * W;
   localparam int SW = 2 * W + 2;

   logic                a_zero;
   logic [W-1:0]        den_u;
   logic [PW-1:0]       prod_u;
   logic signed [PW-1:0] prod_s;
   logic [W-1:0]        quo_u, rem_u;
   logic [PW-1:0]       frac_u;
   logic signed [W:0]   b_s, a_s, quo_s;
   logic signed [SW-1:0] num_s, den_s, frac_s;

   always_comb begin
      a_zero = (a == '0);
      den_u  = a_zero ? {{(W-1){1'b0}}, 1'b1} : a;
      prod_u = {{W{1'b0}}, b} * {{W{1'b0}}, a};
      prod_s = $signed({{W{b[W-1]}}, b}) * $signed({{W{a[W-1]}}, a});
      quo_u  = b / den_u;
      rem_u  = b % den_u;
      frac_u = {b, {W{1'b0}}} / {{W{1'b0}}, den_u};
      b_s    = $signed({b[W-1], b});
      a_s    = a_zero ? $signed({{W{1'b0}}, 1'b1}) : $signed({a[W-1], a});
      quo_s  = b_s / a_s;
      num_s  = $signed({{2{b[W-1]}}, b, {W{1'b0}}});
      den_s  = $signed({{(W+1){a_s[W]}}, a_s});
      frac_s = num_s / den_s;
   end

   always_comb begin
      res   = '0;
      xs_nx = xs;
      case (op)
         OP_MULU: begin
            res   = prod_u[W-1:0];
            xs_nx = prod_u[PW-1:W];
         end
         OP_MULS: begin
            res   = prod_s[W-1:0];
            xs_nx = prod_s[PW-1:W];
         end
         OP_DIVU: begin
            res   = a_zero ? '0 : quo_u;
            xs_nx = a_zero ? '0 : frac_u[W-1:0];
         end
         OP_DIVS: begin
            res   = a_zero ? '0 : quo_s[W-1:0];
            xs_nx = a_zero ? '0 : frac_s[W-1:0];
         end
         OP_REM: res = a_zero ? '0 : rem_u;
         default: ;
      endcase
   end
endmodule

// File: rtl/exw_shifter.sv
module exw_shifter
   import exw_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [4:0]   op,
   input  logic [W-1:0] b,
   input  logic [W-1:0] a,
   input  logic [W-1:0] xs,
   output logic [W-1:0] res,
   output logic [W-1:0] xs_nx
);
   localparam int DW = 2 * W;

   logic [DW-1:0]        left_w, right_w;
   logic signed [DW-1:0] arith_w;

   always_comb begin
      left_w  = {{W{1'b0}}, b} << a;
      right_w = {b, {W{1'b0}}} >> a;
      arith_w = $signed({b, {W{1'b0}}}) >>> a;
   end

   always_comb begin
      res   = '0;
      xs_nx = xs;
      case (op)
         OP_SLL: begin
            res   = left_w[W-1:0];
            xs_nx = left_w[DW-1:W];
         end
         OP_SRL: begin
            res   = right_w[DW-1:W];
            xs_nx = right_w[W-1:0];
         end
         OP_SRA: begin
            res   = arith_w[DW-1:W];
            xs_nx = arith_w[W-1:0];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/exw_alu.sv
module exw_alu
   import exw_pkg::*;
#(
   parameter int W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [4:0]         op,
   input  logic [W-1:0]       b_in,
   input  logic [W-1:0]       a_in,
   output logic               out_valid,
   output logic [W-1:0]       result,
   output logic               wr_en,
   output logic [W-1:0]       xs_out,
   output logic               idx_inc,
   output logic [COST_W-1:0]  cost
);
   localparam int NUNIT = 3;

   generate
      if (W < 4 || W > 32) begin : g_bad_width
         $error("exw_alu: W must lie in 4..32");
      end
   endgenerate

   logic [W-1:0] xs_q;
   logic [W-1:0] u_res [NUNIT];
   logic [W-1:0] u_xs  [NUNIT];
   logic [W-1:0] res_nx, xs_nx;

   exw_addsub  #(.W(W)) u_as (.op(op), .b(b_in), .a(a_in), .xs(xs_q),
                              .res(u_res[0]), .xs_nx(u_xs[0]));
   exw_muldiv  #(.W(W)) u_md (.op(op), .b(b_in), .a(a_in), .xs(xs_q),
                              .res(u_res[1]), .xs_nx(u_xs[1]));
   exw_shifter #(.W(W)) u_sh (.op(op), .b(b_in), .a(a_in), .xs(xs_q),
                              .res(u_res[2]), .xs_nx(u_xs[2]));

   always_comb begin
      res_nx = '0;
      xs_nx  = xs_q;
      case (op)
         OP_MOVE, OP_MOVINC: res_nx = a_in;
         OP_AND:             res_nx = b_in & a_in;
         OP_OR:              res_nx = b_in | a_in;
         OP_XOR:             res_nx = b_in ^ a_in;
         OP_ADD, OP_SUB, OP_ADDC, OP_SUBB: begin
            res_nx = u_res[0];
            xs_nx  = u_xs[0];
         end
         OP_MULU, OP_MULS, OP_DIVU, OP_DIVS, OP_REM: begin
            res_nx = u_res[1];
            xs_nx  = u_xs[1];
         end
         OP_SLL, OP_SRL, OP_SRA: begin
            res_nx = u_res[2];
            xs_nx  = u_xs[2];
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         wr_en     <= 1'b0;
         idx_inc   <= 1'b0;
         result    <= '0;
         cost      <= '0;
         xs_q      <= '0;
      end else begin
         out_valid <= in_valid;
         wr_en     <= in_valid && op_legal(op);
         idx_inc   <= in_valid && (op == OP_MOVINC);
         if (in_valid) begin
            result <= res_nx;
            cost   <= op_cost(op);
            xs_q   <= xs_nx;
         end
      end
   end

   assign xs_out = xs_q;
endmodule

// File: rtl/exw_alu_chk.sv
module exw_alu_chk
   import exw_pkg::*;
#(
   parameter int W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [4:0]         op,
   input logic [W-1:0]       b_in,
   input logic [W-1:0]       a_in,
   input logic               out_valid,
   input logic [W-1:0]       result,
   input logic               wr_en,
   input logic [W-1:0]       xs_out,
   input logic               idx_inc,
   input logic [COST_W-1:0]  cost
);
   a_r2_idle_no_output: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !wr_en && !idx_inc);

   a_r2_unlisted_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !op_legal(op) |=> !wr_en && xs_out == $past(xs_out));

   a_r3_xs_held: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (op inside {OP_MOVE, OP_AND, OP_OR, OP_XOR, OP_REM, OP_MOVINC})
      |=> xs_out == $past(xs_out));

   a_r4_carry_flag: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op == OP_ADD |=> (xs_out == 16'h0000 || xs_out == 16'h0001));

   a_r5_borrow_mask: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op == OP_SUB |=> (xs_out == '0 || xs_out == '1));

   a_r7_div_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (op == OP_DIVU || op == OP_DIVS) && a_in == '0
      |=> result == '0 && xs_out == '0);

   a_r8_rem_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op == OP_REM && a_in == '0 |=> result == '0);

   a_r11_inc_request: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op == OP_MOVINC |=> idx_inc && result == $past(a_in));

   a_r11_inc_only_there: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && op == OP_MOVINC) |=> !idx_inc);

   a_r13_cost_with_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> cost != '0);

   a_r13_no_cost_unlisted: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !wr_en |-> cost == '0);
endmodule

bind exw_alu exw_alu_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
   .b_in(b_in), .a_in(a_in), .out_valid(out_valid), .result(result),
   .wr_en(wr_en), .xs_out(xs_out), .idx_inc(idx_inc), .cost(cost)
);

// File: tb/sim_exw_alu.sv
module sim_exw_alu;
   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYC   = 20000;

   localparam logic [4:0] K_MOVE = 5'h01, K_ADD = 5'h02, K_SUB = 5'h03,
      K_MULU = 5'h04, K_MULS = 5'h05, K_DIVU = 5'h06, K_DIVS = 5'h07,
      K_REM = 5'h08, K_AND = 5'h09, K_OR = 5'h0a, K_XOR = 5'h0b,
      K_SRL = 5'h0c, K_SRA = 5'h0d, K_SLL = 5'h0e, K_MOVINC = 5'h0f,
      K_ADDC = 5'h1a, K_SUBB = 5'h1b;

   typedef struct {
      logic [15:0] res;
      logic [15:0] xs;
      logic        wr;
      logic        inc;
      logic [1:0]  cst;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [4:0]  op = '0;
   logic [15:0] b_in = '0, a_in = '0;
   logic        out_valid, wr_en, idx_inc;
   logic [15:0] result, xs_out;
   logic [1:0]  cost;

   int total = 0;
   int bad = 0;
   logic [15:0] mdl_xs = '0;
   exp_t sb_q[$];
   bit finished = 1'b0;

   exw_alu u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .b_in(b_in), .a_in(a_in), .out_valid(out_valid), .result(result),
      .wr_en(wr_en), .xs_out(xs_out), .idx_inc(idx_inc), .cost(cost)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string what, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic void model(input logic [4:0] o, input logic [15:0] bv, input logic [15:0] av,
                                 inout logic [15:0] xs, output exp_t e);
      longint ub, ua, sbv, sav, p;
      ub  = longint'(bv);
      ua  = longint'(av);
      sbv = longint'(shortint'(bv));
      sav = longint'(shortint'(av));
      e.res = 16'h0; e.wr = 1'b1; e.inc = 1'b0; e.cst = 2'd0;
      case (o)
         K_MOVE:   begin e.res = av; e.cst = 2'd1; end
         K_AND:    begin e.res = bv & av; e.cst = 2'd1; end
         K_OR:     begin e.res = bv | av; e.cst = 2'd1; end
         K_XOR:    begin e.res = bv ^ av; e.cst = 2'd1; end
         K_MOVINC: begin e.res = av; e.inc = 1'b1; e.cst = 2'd2; end
         K_ADD: begin
            p = ub + ua; e.res = 16'(p); xs = (p > 65535) ? 16'h0001 : 16'h0000; e.cst = 2'd2;
         end
         K_SUB: begin
            p = ub - ua; e.res = 16'(p); xs = (p < 0) ? 16'hFFFF : 16'h0000; e.cst = 2'd2;
         end
         K_MULU: begin p = ub * ua; e.res = 16'(p); xs = 16'(p >> 16); e.cst = 2'd2; end
         K_MULS: begin p = sbv * sav; e.res = 16'(p); xs = 16'(p >>> 16); e.cst = 2'd2; end
         K_DIVU: begin
            e.cst = 2'd3;
            if (ua == 0) begin e.res = 16'h0; xs = 16'h0; end
            else begin e.res = 16'(ub / ua); xs = 16'((ub * 65536) / ua); end
         end
         K_DIVS: begin
            e.cst = 2'd3;
            if (sav == 0) begin e.res = 16'h0; xs = 16'h0; end
            else begin e.res = 16'(sbv / sav); xs = 16'((sbv * 65536) / sav); end
         end
         K_REM: begin
            e.cst = 2'd3;
            e.res = (ua == 0) ? 16'h0 : 16'(ub % ua);
         end
         K_SLL: begin
            p = (ua >= 48) ? 64'sd0 : (ub << ua);
            e.res = 16'(p); xs = 16'(p >> 16); e.cst = 2'd2;
         end
         K_SRL: begin
            p = (ua >= 48) ? 64'sd0 : ((ub * 65536) >> ua);
            e.res = 16'(p >> 16); xs = 16'(p); e.cst = 2'd2;
         end
         K_SRA: begin
            p = (sbv * 65536) >>> ((ua >= 63) ? 63 : ua);
            e.res = 16'(p >>> 16); xs = 16'(p); e.cst = 2'd2;
         end
         K_ADDC: begin
            p = ub + ua + longint'(xs); e.res = 16'(p);
            xs = (p > 65535) ? 16'h0001 : 16'h0000; e.cst = 2'd3;
         end
         K_SUBB: begin
            p = ub - ua - longint'(xs); e.res = 16'(p);
            xs = (p < 0) ? 16'h0001 : 16'h0000; e.cst = 2'd3;
         end
         default: e.wr = 1'b0;
      endcase
      e.xs = xs;
   endfunction

   task automatic send(input logic [4:0] o, input logic [15:0] bv, input logic [15:0] av,
                       input string tag);
      exp_t e;
      logic [15:0] x;
      x = mdl_xs;
      model(o, bv, av, x, e);
      mdl_xs = x;
      e.tag = tag;
      @(negedge clk);
      in_valid = 1'b1; op = o; b_in = bv; a_in = av;
      sb_q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R2 output with nothing pending", 1, 0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(result == e.res, {e.tag, " result"}, longint'(result), longint'(e.res));
            check(xs_out == e.xs, {e.tag, " excess"}, longint'(xs_out), longint'(e.xs));
            check(wr_en == e.wr, {e.tag, " R2 write strobe"}, longint'(wr_en), longint'(e.wr));
            check(idx_inc == e.inc, {e.tag, " R11 index request"}, longint'(idx_inc), longint'(e.inc));
            check(cost == e.cst, {e.tag, " R13 cost"}, longint'(cost), longint'(e.cst));
         end
      end
   end

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      if (!finished) begin
         check(1'b0, "watchdog expired", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && wr_en == 1'b0 && idx_inc == 1'b0, "R1 flags in reset",
            longint'({out_valid, wr_en, idx_inc}), 0);
      check(xs_out == 16'h0, "R1 excess in reset", longint'(xs_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && xs_out == 16'h0, "R1 after release",
            longint'({out_valid, xs_out}), 0);

      // R3 logic and move, excess untouched
      send(K_MOVE, 16'hAAAA, 16'h1234, "R3 move");
      send(K_AND,  16'hF0F0, 16'h3C3C, "R3 and");
      send(K_OR,   16'hF0F0, 16'h0F01, "R3 or");
      send(K_XOR,  16'hFFFF, 16'h1234, "R3 xor");
      // R4 add carry and no carry
      send(K_ADD,  16'hFFFF, 16'h0001, "R4 add carry");
      send(K_MOVE, 16'h0000, 16'h7777, "R3 move keeps carry");
      send(K_ADD,  16'h0003, 16'h0004, "R4 add plain");
      // R5 subtract
      send(K_SUB,  16'h0001, 16'h0002, "R5 sub borrow");
      // R12 back-to-back chaining on the fresh excess value
      send(K_ADDC, 16'h0001, 16'h0001, "R12 addc after borrow mask");
      send(K_ADDC, 16'hFFFF, 16'h0000, "R12 addc carry in");
      send(K_SUBB, 16'h0005, 16'h0003, "R12 subb with borrow in");
      send(K_SUBB, 16'h0000, 16'h0001, "R12 subb negative");
      send(K_SUBB, 16'h0010, 16'h0000, "R12 subb chained");
      send(K_SUB,  16'h0005, 16'h0003, "R5 sub plain");
      // R6 multiplies
      send(K_MULU, 16'hFFFF, 16'hFFFF, "R6 mulu");
      send(K_MULS, 16'hFFFF, 16'h0002, "R6 muls negative");
      send(K_MULS, 16'h8000, 16'h8000, "R6 muls extreme");
      // R7 divides
      send(K_DIVU, 16'h0007, 16'h0002, "R7 divu");
      send(K_DIVU, 16'h1234, 16'h0000, "R7 divu by zero");
      send(K_DIVS, 16'hFFF9, 16'h0002, "R7 divs negative");
      send(K_DIVS, 16'h8000, 16'hFFFF, "R7 divs overflow");
      send(K_DIVS, 16'h0064, 16'hFFFD, "R7 divs mixed sign");
      send(K_ADDC, 16'h0000, 16'h0000, "R12 addc after fraction");
      send(K_DIVS, 16'h4321, 16'h0000, "R7 divs by zero");
      // R8 remainder
      send(K_MULU, 16'h0100, 16'h0100, "R6 mulu setup");
      send(K_REM,  16'h0011, 16'h0005, "R8 rem");
      send(K_REM,  16'h0011, 16'h0000, "R8 rem by zero");
      // R9 logical shifts
      send(K_SLL,  16'h8001, 16'h0001, "R9 sll");
      send(K_SLL,  16'hABCD, 16'h0014, "R9 sll past width");
      send(K_SLL,  16'hABCD, 16'h0028, "R9 sll huge");
      send(K_SRL,  16'h0003, 16'h0001, "R9 srl");
      send(K_SRL,  16'hBEEF, 16'h0010, "R9 srl by 16");
      send(K_SRL,  16'hBEEF, 16'h0100, "R9 srl huge");
      // R10 arithmetic shift
      send(K_SRA,  16'h8000, 16'h0004, "R10 sra negative");
      send(K_SRA,  16'h8001, 16'h0001, "R10 sra shifted out");
      send(K_SRA,  16'h7FFF, 16'h0003, "R10 sra positive");
      send(K_SRA,  16'hFFFF, 16'h0064, "R10 sra huge");
      send(K_SUBB, 16'h0000, 16'h0000, "R12 subb after sra");
      // R11 move with increment
      send(K_MOVINC, 16'h0000, 16'h5A5A, "R11 movinc");
      // R2 unlisted codes
      send(K_ADD,  16'hFFFF, 16'hFFFF, "R4 add setup");
      send(5'h00,  16'h1111, 16'h2222, "R2 code 00");
      send(5'h10,  16'h1111, 16'h2222, "R2 code 10");
      send(5'h1f,  16'h1111, 16'h2222, "R2 code 1f");
      send(K_MOVINC, 16'h0000, 16'h0001, "R11 movinc second");
      idle(2);
      check(out_valid == 1'b0 && idx_inc == 1'b0, "R2 idle no output",
            longint'({out_valid, idx_inc}), 0);
      check(xs_out == mdl_xs, "R2 idle keeps excess", longint'(xs_out), longint'(mdl_xs));
      // R2 gap between ops
      send(K_MULU, 16'h1234, 16'h0010, "R6 mulu after gap");
      idle(1);
      send(K_ADDC, 16'h0001, 16'h0002, "R12 addc after gap");
      idle(3);
      check(sb_q.size() == 0, "R2 all results seen", longint'(sb_q.size()), 0);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule